// File: doc/BRIEF.md
# Pattern-Match and Change-of-State Port Interrupt Controller

This block runs one 8-bit general-purpose digital port. It also watches the port pins and raises an interrupt when they meet a programmed condition. A small synchronous register bus reaches three locations:

- a port data register;
- a control register;
- a shared slot. The control register picks which of four internal registers the shared slot reaches: direction, live pin state, mask or compare.

One mask register serves two purposes. With the interrupt feature off, a set mask bit freezes that output bit against port data writes. With the interrupt feature on, a set mask bit removes that pin from the interrupt test.

The interrupt test has two modes. In match mode, the interrupt fires when the unmasked synchronized pins equal the compare register. In event mode, it fires when any unmasked synchronized pin changes from its previous sample. The value that caused the event is then captured into the compare register, where software reads it back. The interrupt is a level. It holds until software writes a clear bit.

Top module: `pmio_irq_ctrl`

## Requirements
- R1: After reset, irq, pin_out and pin_oe are 0, and every register reads 0.
- R2: The bus has four addresses: 0 is port data, 1 is control, 2 is the shared slot, and 3 always reads 0. The control register holds three fields:
  - bits 1:0 are the slot select (00 direction, 01 pin state, 10 mask, 11 compare);
  - bit 2 is the interrupt enable;
  - bit 3 is the mode (1 match, 0 event).
  Bit 4 is a write-1 clear that reads as 0. Bits 7:5 read as 0.
- R3: A direction bit of 1 drives the matching pin_oe bit high. pin_out shows the port data register, and address 0 reads it back.
- R4: With the enable at 0, a port data write leaves every bit whose mask bit is 1 unchanged and loads every other bit. With the enable at 1, all bits load.
- R5: Pins pass through a two-stage synchronizer. Slot code 01 reads a pin value two clock edges after it is applied. A write to slot code 01 changes no register.
- R6: In match mode with the enable at 1, irq rises on the clock edge after the synchronized pins equal the compare register on every bit whose mask bit is 0. Masked bits do not affect the result.
- R7: In match mode, clearing irq while the match still holds does not raise irq again. irq fires again only after the condition has been false for at least one cycle and then becomes true again.
- R8: In event mode with the enable at 1, irq rises on the clock edge after any unmasked synchronized pin differs from its previous sample. Changes on masked pins are ignored.
- R9: In event mode, the synchronized pin value is captured into the compare register on the same edge on which irq rises. Slot code 11 reads it back. Later pin changes do not overwrite it while irq is set.
- R10: Once set, irq stays high until a control write with bit 4 at 1. An enable of 0 drives irq low one cycle later and keeps it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Raw port pin levels |
| pin_out | output | 8 | Port output levels |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- the interrupt level rules: irq holds, a clear drops it, and an enable of 0 forces it low;
- every rising edge of irq has a cause one cycle earlier in the active mode;
- match mode does not re-fire while disarmed;
- masked output bits stay frozen across port writes with the enable at 0;
- the captured value is held while irq is set;
- writes to the pin-state slot have no effect.

Only the bench scenarios can show the rest:
- the exact two-edge synchronizer latency;
- the full re-arm sequence after the match condition drops;
- the captured value matching the pin pattern that was applied.

// File: rtl/pmio_pkg.sv
package pmio_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SLOT = 2'd2;

  localparam int CTRL_EN_BIT    = 2;
  localparam int CTRL_MODE_BIT  = 3;
  localparam int CTRL_CLR_BIT   = 4;
  localparam int CTRL_STORED_W  = 4;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'b00,
    SEL_PIN  = 2'b01,
    SEL_MASK = 2'b10,
    SEL_CMP  = 2'b11
  } slot_sel_e;

  typedef struct packed {
    logic      match_mode;
    logic      irq_en;
    slot_sel_e sel;
  } ctrl_t;

endpackage

// File: rtl/pmio_sync.sv
module pmio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pmio_regs.sv
module pmio_regs
  import pmio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic              irq_i,
  input  logic              capture_i,
  output ctrl_t             ctrl_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  cmp_q,
  output logic [WIDTH-1:0]  out_q,
  output logic              clr_pulse
);

  localparam int PAD_W = WIDTH - CTRL_STORED_W;

  logic ctrl_wr, port_wr, slot_wr;
  logic ctrl_en, dir_en, mask_en, cmp_en, out_en;
  ctrl_t            ctrl_d;
  logic [WIDTH-1:0] dir_d, mask_d, cmp_d, out_d;

  always_comb begin
    ctrl_wr   = bus_we && (bus_addr == ADDR_CTRL);
    port_wr   = bus_we && (bus_addr == ADDR_PORT);
    slot_wr   = bus_we && (bus_addr == ADDR_SLOT);
    clr_pulse = ctrl_wr && bus_wdata[CTRL_CLR_BIT];

    ctrl_en = ctrl_wr;
    ctrl_d  = '{match_mode: bus_wdata[CTRL_MODE_BIT],
                irq_en:     bus_wdata[CTRL_EN_BIT],
                sel:        slot_sel_e'(bus_wdata[1:0])};

    dir_en  = slot_wr && (ctrl_q.sel == SEL_DIR);
    dir_d   = bus_wdata;
    mask_en = slot_wr && (ctrl_q.sel == SEL_MASK);
    mask_d  = bus_wdata;

    cmp_en = capture_i || (slot_wr && (ctrl_q.sel == SEL_CMP));
    cmp_d  = capture_i ? pin_sync : bus_wdata;

    out_en = port_wr;
    if (ctrl_q.irq_en) out_d = bus_wdata;
    else               out_d = (out_q & mask_q) | (bus_wdata & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_PORT: bus_rdata = out_q;
      ADDR_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_SLOT: begin
        unique case (ctrl_q.sel)
          SEL_DIR:  bus_rdata = dir_q;
          SEL_PIN:  bus_rdata = pin_sync;
          SEL_MASK: bus_rdata = mask_q;
          SEL_CMP:  bus_rdata = cmp_q;
        endcase
      end
      default:   bus_rdata = '0;
    endcase
  end

  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !ctrl_q.irq_en) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0)); // R4

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !ctrl_q.match_mode && !(slot_wr && ctrl_q.sel == SEL_CMP)) |=> $stable(cmp_q)); // R9

  AST_PIN_SLOT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && ctrl_q.sel == SEL_PIN) |=> ($stable(dir_q) && $stable(mask_q))); // R5

endmodule

// File: rtl/pmio_irq_gen.sv
module pmio_irq_gen #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] cmp,
  input  logic             irq_en,
  input  logic             match_mode,
  input  logic             clr,
  output logic             irq_q,
  output logic             capture
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] diff_cmp, diff_prev;
  logic             cond, chg, fire, armed_q, armed_d, irq_d;

  always_comb begin
    diff_cmp  = (pin_sync ^ cmp) & ~mask;
    diff_prev = (pin_sync ^ prev_q) & ~mask;
    cond      = (diff_cmp == '0);
    chg       = (diff_prev != '0);
    fire      = irq_en && !irq_q && (match_mode ? (cond && armed_q) : chg);
    capture   = fire && !match_mode;
    irq_d     = irq_en && ((irq_q && !clr) || fire);
    if (!cond)                    armed_d = 1'b1;
    else if (fire && match_mode)  armed_d = 1'b0;
    else                          armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= pin_sync;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q); // R10

  AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && irq_en && !clr) |=> irq_q); // R10

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && clr) |=> !irq_q); // R10

  AST_MATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(match_mode)) |-> $past(cond && armed_q)); // R6

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_mode && !armed_q && !irq_q) |=> !irq_q); // R7

  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && !$past(match_mode)) |-> $past(chg)); // R8

endmodule

// File: rtl/pmio_irq_ctrl.sv
module pmio_irq_ctrl
  import pmio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);

  logic             rst_meta_n, rst_core_n;
  logic [WIDTH-1:0] pin_sync, dir_q, mask_q, cmp_q, out_q;
  ctrl_t            ctrl_q;
  logic             clr_pulse, capture, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  pmio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  pmio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .irq_i     (irq_q),
    .capture_i (capture),
    .ctrl_q    (ctrl_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .cmp_q     (cmp_q),
    .out_q     (out_q),
    .clr_pulse (clr_pulse)
  );

  pmio_irq_gen #(.WIDTH(WIDTH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pin_sync   (pin_sync),
    .mask       (mask_q),
    .cmp        (cmp_q),
    .irq_en     (ctrl_q.irq_en),
    .match_mode (ctrl_q.match_mode),
    .clr        (clr_pulse),
    .irq_q      (irq_q),
    .capture    (capture)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> $past(ctrl_q.irq_en)); // R10

endmodule

// File: tb/pmio_irq_ctrl_bench.sv
module pmio_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] pin_in = 8'd0;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit run_cmp = 0;

  always #5 clk = ~clk;

  pmio_irq_ctrl u_pmio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference state
  logic [7:0] m_s1, m_s2, m_prev, m_dir, m_mask, m_cmp, m_out;
  logic [1:0] m_sel;
  logic       m_en, m_match, m_irq, m_armed;
  logic       m_cond, m_chg, m_clr, m_fire, m_nirq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_mask = 0; m_cmp = 0; m_out = 0;
      m_sel = 0; m_en = 0; m_match = 0; m_irq = 0; m_armed = 1;
    end else begin
      m_cond = 1'b1;
      m_chg  = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (!m_mask[i] && (m_s2[i] != m_cmp[i]))  m_cond = 1'b0;
        if (!m_mask[i] && (m_s2[i] != m_prev[i])) m_chg  = 1'b1;
      end
      m_clr  = bus_we && bus_addr == 2'd1 && bus_wdata[4];
      m_fire = m_en && !m_irq && (m_match ? (m_cond && m_armed) : m_chg);
      m_nirq = m_en && ((m_irq && !m_clr) || m_fire);
      if (!m_cond) m_armed = 1'b1;
      else if (m_fire && m_match) m_armed = 1'b0;
      if (bus_we && bus_addr == 2'd0) begin
        for (int i = 0; i < 8; i++)
          if (m_en || !m_mask[i]) m_out[i] = bus_wdata[i];
      end
      if (bus_we && bus_addr == 2'd2) begin
        if (m_sel == 2'd0) m_dir  = bus_wdata;
        if (m_sel == 2'd2) m_mask = bus_wdata;
        if (m_sel == 2'd3) m_cmp  = bus_wdata;
      end
      if (m_fire && !m_match) m_cmp = m_s2;
      if (bus_we && bus_addr == 2'd1) begin
        m_sel = bus_wdata[1:0]; m_en = bus_wdata[2]; m_match = bus_wdata[3];
      end
      m_irq = m_nirq; m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_out;
      2'd1: return {4'd0, m_match, m_en, m_sel};
      2'd2: case (m_sel)
              2'd0: return m_dir;
              2'd1: return m_s2;
              2'd2: return m_mask;
              default: return m_cmp;
            endcase
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R10 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      chk("R4 pin_out vs model", pin_out, m_out);
      chk("R3 pin_oe vs model", pin_oe, m_dir);
      chk("R2 rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(5);
    run_cmp = 1;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    rd_chk("R1 ctrl", 2'd1, 8'h00);
    rd_chk("R1 dir", 2'd2, 8'h00);
    // R2 control field layout
    wr(2'd1, 8'hEB);
    rd_chk("R2 ctrl readback", 2'd1, 8'h0B);
    rd_chk("R2 addr3 zero", 2'd3, 8'h00);
    // R3 direction and port data
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hF0);
    chk("R3 pin_oe", pin_oe, 8'hF0);
    wr(2'd0, 8'h5A);
    chk("R3 pin_out", pin_out, 8'h5A);
    rd_chk("R3 port read", 2'd0, 8'h5A);
    // R4 mask freezes outputs when disabled
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'hA5);
    chk("R4 masked write", pin_out, 8'hAA);
    wr(2'd1, 8'h06);
    wr(2'd0, 8'h33);
    chk("R4 enabled write", pin_out, 8'h33);
    wr(2'd1, 8'h02);
    // R5 synchronizer latency and read-only slot
    wr(2'd1, 8'h01);
    bus_addr = 2'd2;
    pin_in = 8'h3C;
    tick();
    chk("R5 one edge", bus_rdata, 8'h00);
    tick();
    chk("R5 two edges", bus_rdata, 8'h3C);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00);
    rd_chk("R5 dir untouched", 2'd2, 8'hF0);
    wr(2'd1, 8'h02);
    rd_chk("R5 mask untouched", 2'd2, 8'h0F);
    // R6 match mode
    wr(2'd1, 8'h0B);
    wr(2'd2, 8'h50);
    wr(2'd1, 8'h0F);
    tick(3);
    chk("R6 no match", {7'd0, irq}, 8'd0);
    pin_in = 8'h5F;
    tick(2);
    chk("R6 before edge", {7'd0, irq}, 8'd0);
    tick();
    chk("R6 match fires", {7'd0, irq}, 8'd1);
    // R7 re-arm only after condition drops
    wr(2'd1, 8'h1F);
    chk("R7 cleared", {7'd0, irq}, 8'd0);
    tick(4);
    chk("R7 no refire", {7'd0, irq}, 8'd0);
    pin_in = 8'h00;
    tick(3);
    chk("R7 mismatch", {7'd0, irq}, 8'd0);
    pin_in = 8'h53;
    tick(2);
    chk("R7 before edge", {7'd0, irq}, 8'd0);
    tick();
    chk("R7 refires", {7'd0, irq}, 8'd1);
    // R10 level hold and disable
    tick(5);
    chk("R10 holds", {7'd0, irq}, 8'd1);
    wr(2'd1, 8'h0B);
    tick();
    chk("R10 disabled", {7'd0, irq}, 8'd0);
    pin_in = 8'hAA;
    tick(4);
    chk("R10 stays low", {7'd0, irq}, 8'd0);
    // R8 event mode
    wr(2'd1, 8'h07);
    tick(3);
    chk("R8 quiet", {7'd0, irq}, 8'd0);
    pin_in = 8'hA5;
    tick(4);
    chk("R8 masked change", {7'd0, irq}, 8'd0);
    pin_in = 8'h95;
    tick(2);
    chk("R8 before edge", {7'd0, irq}, 8'd0);
    tick();
    chk("R8 event fires", {7'd0, irq}, 8'd1);
    rd_chk("R9 captured", 2'd2, 8'h95);
    // R9 capture held until clear
    pin_in = 8'h15;
    tick(4);
    chk("R9 irq held", {7'd0, irq}, 8'd1);
    rd_chk("R9 not overwritten", 2'd2, 8'h95);
    wr(2'd1, 8'h17);
    chk("R9 cleared", {7'd0, irq}, 8'd0);
    tick(3);
    chk("R9 no new event", {7'd0, irq}, 8'd0);
    rd_chk("R9 still held", 2'd2, 8'h95);
    pin_in = 8'hE5;
    tick(3);
    chk("R9 second event", {7'd0, irq}, 8'd1);
    rd_chk("R9 new capture", 2'd2, 8'hE5);
    tick(2);
    done = 1;
    summary();
    $finish;
  end

endmodule